// File: doc/BRIEF.md
# Write-Only Serial Wiper Command Slave

This block is the two-wire serial front end of a digital potentiometer controller. It oversamples the clock and data lines with the system clock and recognises bus start and stop conditions. It shifts in an address byte, a command byte and a data byte. For each byte it accepts, it acknowledges by pulling the data line low through an open-drain enable.

When an addressed write completes, the block emits a one-cycle strobe to the register controller. The strobe carries the command byte and the data byte. Bit 0 of the command byte targets the volatile wiper register and bit 1 targets the nonvolatile one. If the final address bit is high, the access is a no-operation: the address is acknowledged and nothing else happens.

The device address has seven bits. The upper four bits are the constant 0101. The next two bits are a build-time parameter. The lowest bit is taken from a strap pin. Bits travel most significant first, and SDA is valid while SCL is high.

Top module: `wiper_i2c_slave`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe_o` and `wr_stb_o` are both 0.
- R2: An address byte whose upper seven bits equal {0101, FIXED_BITS, addr_pin_i} is acknowledged: SDA is held low during the high phase of the 9th clock.
- R3: An address byte that does not match is not acknowledged. Every byte after it stays unacknowledged and produces no strobe until the next START.
- R4: A matching address whose 8th bit (LSB) is 1 is acknowledged. It produces no strobe, and the bytes that follow it are not acknowledged.
- R5: A matching address with 8th bit 0, then a command byte and a data byte, gets both bytes acknowledged. If command bit 0 or bit 1 is set, the block raises `wr_stb_o` exactly once, with `wr_cmd_o` equal to the command byte and `wr_data_o` equal to the data byte.
- R6: A command byte with bits [1:0] equal to 00 is acknowledged, as is its data byte, but no strobe is produced.
- R7: A STOP that arrives before the 8th bit of the data byte discards the transaction: no strobe is produced.
- R8: A START that arrives in the middle of a byte restarts address reception. A full transaction after it behaves as in R5.
- R9: A byte sent after the data byte, within the same transaction, is not acknowledged.
- R10: The acknowledge drive is raised only while the synchronised SCL is low. It stays in place from before the 9th clock rises until after that clock falls.
- R11: `wr_stb_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pin_i | input | 1 | Strap pin giving address bit 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_cmd_o | output | 8 | Command byte; bit 0 volatile, bit 1 nonvolatile |
| wr_data_o | output | 8 | Data byte for the selected register(s) |

## Verification
The hardest cases to reach are bus conditions that break into a byte: a repeated START after a few command bits, or a STOP after part of the data byte. Normal transfers never produce them. The stimulus reaches them through transaction modes that cut a frame at a chosen bit count. These modes are mixed at random with mismatched addresses, no-operation addresses, strap-pin changes and command values whose select bits are clear. The acknowledge is sampled both early and late in the 9th clock's high phase, which shows whether it is held across the whole phase.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] ADDR_PREFIX = 4'b0101;
  localparam int CMD_VOL_BIT = 0;
  localparam int CMD_NV_BIT  = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK} link_state_e;
  typedef enum logic [1:0] {SLOT_ADDR, SLOT_CMD, SLOT_DATA} slot_e;
endpackage

// File: rtl/wcs_line_sync.sv
module wcs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int DEPTH = STAGES + 1;

  logic [1:0] raw, lvl, prv;
  assign raw = {sda_i, scl_i};

  // per line: STAGES synchroniser flops plus one history flop for edges
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;
      else         pipe <= {pipe[DEPTH-2:0], raw[g]};
    end
    assign lvl[g] = pipe[STAGES-1];
    assign prv[g] = pipe[STAGES];
  end

  assign scl_lvl_o  = lvl[0];
  assign sda_lvl_o  = lvl[1];
  assign scl_rise_o = lvl[0] & ~prv[0];
  assign scl_fall_o = ~lvl[0] & prv[0];
  assign start_o    = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stop_o     = lvl[0] & prv[0] & ~prv[1] & lvl[1];
endmodule

// File: rtl/wcs_frame_fsm.sv
module wcs_frame_fsm
  import wcs_pkg::*;
#(
  parameter logic [1:0] FIXED_BITS = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_pin_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_cmd_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  link_state_e       state_q;
  slot_e             slot_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, cmd_q, data_q;
  logic              nop_q, sda_oe_q, wr_stb_q;
  logic [ADDR_W-1:0] own_addr;
  logic              addr_hit, cmd_selects;

  assign own_addr    = {ADDR_PREFIX, FIXED_BITS, addr_pin_i};
  assign addr_hit    = shreg_q[BYTE_W-1:1] == own_addr;
  assign cmd_selects = cmd_q[CMD_VOL_BIT] | cmd_q[CMD_NV_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      slot_q    <= SLOT_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      cmd_q     <= '0;
      data_q    <= '0;
      nop_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_stb_q  <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (start_i) begin
        // START or repeated START: always restart address reception
        state_q   <= ST_RECV;
        slot_q    <= SLOT_ADDR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RECV: begin
            if (scl_rise_i && bit_cnt_q != FULL_CNT) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == FULL_CNT) begin
              unique case (slot_q)
                SLOT_ADDR: begin
                  if (addr_hit) begin
                    sda_oe_q <= 1'b1;
                    state_q  <= ST_ACK;
                    nop_q    <= shreg_q[0];
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                SLOT_CMD: begin
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_ACK;
                  cmd_q    <= shreg_q;
                end
                default: begin
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_ACK;
                  data_q   <= shreg_q;
                  wr_stb_q <= cmd_selects;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_q  <= 1'b0;
              bit_cnt_q <= '0;
              unique case (slot_q)
                SLOT_ADDR: begin
                  if (nop_q) state_q <= ST_IDLE;
                  else begin
                    state_q <= ST_RECV;
                    slot_q  <= SLOT_CMD;
                  end
                end
                SLOT_CMD: begin
                  state_q <= ST_RECV;
                  slot_q  <= SLOT_DATA;
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_stb_o  = wr_stb_q;
  assign wr_cmd_o  = cmd_q;
  assign wr_data_o = data_q;

  assert_stb_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_q |=> !wr_stb_q);

  assert_stb_with_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_q |-> $rose(sda_oe_q));

  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_lvl_i);

  assert_start_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RECV && slot_q == SLOT_ADDR && bit_cnt_q == '0));

  assert_stop_discard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_q && !wr_stb_q && state_q == ST_IDLE));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_q);
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wcs_pkg::*;
#(
  parameter logic [1:0] FIXED_BITS  = 2'b00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_pin_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_cmd_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  wcs_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  wcs_frame_fsm #(.FIXED_BITS(FIXED_BITS)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (scl_lvl),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .addr_pin_i (addr_pin_i),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .wr_cmd_o   (wr_cmd_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: tb/test_wiper_i2c_slave.sv
module test_wiper_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] FIX = 2'b10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic pin = 1'b0;
  logic sda_line;
  logic sda_oe, wr_stb;
  logic [7:0] wr_cmd, wr_data;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, dbl_cnt = 0;
  logic prev_stb = 1'b0;
  logic [7:0] last_cmd = '0, last_data = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = !(m_sda_low || sda_oe);

  wiper_i2c_slave #(.FIXED_BITS(FIX), .SYNC_STAGES(2)) i_wiper_i2c_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pin_i(pin), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_cmd_o(wr_cmd), .wr_data_o(wr_data));

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt++;
      last_cmd  = wr_cmd;
      last_data = wr_data;
      if (prev_stb) dbl_cnt++;
    end
    prev_stb = wr_stb;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wait_clk(4);
    m_scl = 1'b1;     wait_clk(8);
    m_sda_low = 1'b1; wait_clk(8);
    m_scl = 1'b0;     wait_clk(4);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_clk(4);
    m_scl = 1'b1;     wait_clk(8);
    m_sda_low = 1'b0; wait_clk(8);
  endtask

  task automatic send_bit(logic b);
    m_sda_low = !b; wait_clk(4);
    m_scl = 1'b1;   wait_clk(8);
    m_scl = 1'b0;   wait_clk(4);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack_e, output logic ack_l);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda_low = 1'b0; wait_clk(4);
    m_scl = 1'b1; wait_clk(1);
    ack_e = !sda_line; wait_clk(6);
    ack_l = !sda_line; wait_clk(1);
    m_scl = 1'b0; wait_clk(4);
  endtask

  function automatic int exp_strobes(logic hit, logic rw, logic [7:0] cmd, int mode);
    bit full = (mode != 1) && (mode != 2);
    return (full && hit && !rw && (cmd[1:0] != 2'b00)) ? 1 : 0;
  endfunction

  // mode: 0 normal, 1 stop after command, 2 stop inside data,
  //       3 extra byte after data, 4 restart inside command then normal
  task automatic run_txn(logic [6:0] a, logic rw, logic [7:0] cmd, logic [7:0] data, int mode);
    logic [6:0] dev = {4'b0101, FIX, pin};
    logic hit = (a == dev);
    logic wr_ok = hit && !rw;
    int exp_n = exp_strobes(hit, rw, cmd, mode);
    int base = stb_cnt;
    logic ae, al;
    string areq = !hit ? "R3" : (rw ? "R4" : "R2");
    string breq = wr_ok ? ((cmd[1:0] == 2'b00) ? "R6" : "R5") : (hit ? "R4" : "R3");
    string sreq;
    bus_start();
    if (mode == 4) begin
      send_byte({a, rw}, ae, al);
      for (int i = 7; i >= 5; i--) send_bit(cmd[i]);
      bus_start();
    end
    send_byte({a, rw}, ae, al);
    chk(areq, al, hit, "address ack");
    if (hit) chk("R10", ae, 1'b1, "ack held from start of 9th high phase");
    send_byte(cmd, ae, al);
    chk(breq, al, wr_ok, "command ack");
    if (mode == 1) begin
      bus_stop();
    end else if (mode == 2) begin
      for (int i = 7; i >= 3; i--) send_bit(data[i]);
      bus_stop();
    end else begin
      send_byte(data, ae, al);
      chk(breq, al, wr_ok, "data ack");
      if (mode == 3) begin
        send_byte(~data, ae, al);
        chk("R9", al, 1'b0, "byte after data ack");
      end
      bus_stop();
    end
    wait_clk(4);
    if (mode == 1 || mode == 2) sreq = "R7";
    else if (mode == 4) sreq = "R8";
    else sreq = breq;
    chk(sreq, stb_cnt - base, exp_n, "strobe count");
    if (exp_n == 1) begin
      chk("R5", last_cmd, cmd, "strobe command");
      chk("R5", last_data, data, "strobe data");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] dev;
    int unsigned seed_val;
    seed_val = $urandom(32'd7731);
    wait_clk(3);
    chk("R1", {sda_oe, wr_stb}, 2'b00, "outputs during reset");
    wait_clk(2);
    rst_ni = 1'b1;
    wait_clk(4);
    chk("R1", {sda_oe, wr_stb}, 2'b00, "outputs after reset");

    dev = {4'b0101, FIX, pin};
    run_txn(dev, 1'b0, 8'h01, 8'h15, 0);
    run_txn(dev, 1'b0, 8'h02, 8'h1F, 0);
    run_txn(dev, 1'b0, 8'h03, 8'h00, 0);
    run_txn(dev, 1'b0, 8'h00, 8'h0A, 0);
    run_txn(dev, 1'b0, 8'hFC, 8'h0B, 0);
    run_txn(dev ^ 7'h01, 1'b0, 8'h01, 8'h05, 0);
    run_txn(7'h2B, 1'b0, 8'h01, 8'h05, 0);
    run_txn(dev, 1'b1, 8'h01, 8'h07, 0);
    run_txn(dev, 1'b0, 8'h01, 8'h09, 1);
    run_txn(dev, 1'b0, 8'h02, 8'h11, 2);
    run_txn(dev, 1'b0, 8'h01, 8'h13, 4);
    run_txn(dev, 1'b0, 8'h02, 8'h1E, 3);
    pin = 1'b1;
    wait_clk(4);
    dev = {4'b0101, FIX, pin};
    run_txn(dev, 1'b0, 8'h01, 8'h0C, 0);
    run_txn(dev ^ 7'h01, 1'b0, 8'h01, 8'h0D, 0);

    for (int n = 0; n < 60; n++) begin
      logic [6:0] a;
      logic rw;
      logic [7:0] cmd, data;
      int mode;
      pin = 1'($urandom % 2);
      wait_clk(4);
      dev = {4'b0101, FIX, pin};
      a = ($urandom % 10 < 7) ? dev : 7'($urandom);
      rw = ($urandom % 5 == 0);
      cmd = 8'($urandom);
      data = 8'($urandom);
      mode = int'($urandom % 8);
      if (mode > 4) mode = 0;
      run_txn(a, rw, cmd, data, mode);
    end

    chk("R11", dbl_cnt, 0, "back-to-back strobe cycles");
    chk("R1", sda_oe, 1'b0, "drive released when idle");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule